// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial command decoder of a byte-addressed non-volatile memory. When a write command begins, the decoder loads the start address. Each data byte then goes into a 64-entry page latch at the offset given by the low six bits of the address pointer. Only those six bits advance, so a long burst wraps inside the current page. When more than a page of data arrives, later bytes overwrite earlier ones, and only the last byte written to each position is kept.

Nothing reaches the storage array until a Stop arrives. A Stop with buffered data and write-protect low starts a self-timed write cycle. During that cycle the latched positions are written to the array one per clock, in ascending offset order, and `busy` stays high for a fixed number of clocks. While `busy` is high the block ignores all command traffic, which lets the decoder refuse to acknowledge it.

Write-protect is sampled only in the Stop cycle. A protected Stop discards the buffer and leaves the block ready for the next command at once. A repeated Start (abort) also discards the buffer, but the pointer keeps its value so that a following read can use it.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and `ptr_addr` is zero.
- R2: An accepted data byte is latched at offset `ptr_addr[5:0]`. Only those six bits then increment, modulo 64, and `ptr_addr[13:6]` never changes because of data bytes.
- R3: When more than 64 bytes arrive in one command, each page position holds the last byte written to it, and exactly 64 array writes follow the Stop.
- R4: `arr_we` is low except in the first 64 clocks of a write cycle. In clock k of the cycle (k from 0 to 63), `arr_we` is high exactly when offset k was written during the command. In that clock `arr_addr` is the page base ORed with k and `arr_wdata` is the latched byte.
- R5: An accepted Stop with buffered data and `wp_in` low raises `busy` in the next clock, and `busy` stays high for exactly CYCLE_CLKS clocks.
- R6: When `wp_in` is high in the Stop cycle, no array write happens, `busy` stays low, and the buffered bytes are discarded: a later Stop with no new bytes writes nothing.
- R7: Changes to `wp_in` after an accepted Stop have no effect on the running write cycle.
- R8: While `busy` is high, `cmd_start`, `byte_vld`, `abort_evt` and `stop_evt` are ignored. `ptr_addr` does not change, and no extra array writes occur.
- R9: A Stop that follows a command with no data bytes starts no write cycle.
- R10: `abort_evt` discards the buffered bytes without a write cycle and leaves `ptr_addr` unchanged.
- R11: A data byte that arrives in the same clock as the Stop is included in the commit.
- R12: After a write, `ptr_addr` points at the location after the last byte written, within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Begin a write command; loads `cmd_addr` and clears the latch |
| cmd_addr | input | ADDR_W | Start address of the command |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition strobe |
| abort_evt | input | 1 | Repeated Start strobe; drops the buffered bytes |
| wp_in | input | 1 | Write-protect level, sampled at Stop |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr_addr | output | ADDR_W | Current address pointer |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
Two events can fall in the same clock here. The first is a data byte arriving together with the Stop: the byte must reach both the latch and the commit decision. The second is the Stop arriving together with a write-protect level, which must decide the cycle even if the level flips on the very next clock. The bench drives `byte_vld` and `stop_evt` high in one cycle, and toggles `wp_in` both in the Stop cycle and in the cycle right after it. A behavioural model predicts `busy`, the pointer and every array write on each clock, and directed checks then read back the collected array image.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Write cycle sequencer states
    typedef enum logic {
        CY_IDLE = 1'b0,
        CY_RUN  = 1'b1
    } cyc_state_e;

    // Per-clock control to the page latch
    typedef struct packed {
        logic load;   // new command: take start address, empty the latch
        logic drop;   // discard buffered positions
        logic wr;     // store one data byte
    } lat_ctl_t;

    // Next in-page offset: wraps inside the page
    function automatic logic [5:0] wrap_inc6(input logic [5:0] off);
        return off + 6'd1;
    endfunction

endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  lat_ctl_t          ctl,
    input  logic [ADDR_W-1:0] load_addr,
    input  byte_t             wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [ADDR_W-1:0] ptr,
    output logic [(1<<PAGE_W)-1:0] mask,
    output byte_t             rd_data
);
    localparam int PAGE = 1 << PAGE_W;

    byte_t             pg_q [PAGE];
    logic [PAGE-1:0]   mask_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] off;

    assign off = ptr_q[PAGE_W-1:0];

    // Address pointer: only the in-page offset advances
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ctl.load) begin
            ptr_q <= load_addr;
        end else if (ctl.wr) begin
            ptr_q[PAGE_W-1:0] <= off + PAGE_W'(1);
        end
    end

    // Valid mask of positions holding new data
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (ctl.load || ctl.drop) begin
            mask_q <= '0;
        end else if (ctl.wr) begin
            mask_q[off] <= 1'b1;
        end
    end

    // Byte storage, one entry per page position
    always_ff @(posedge clk) begin
        if (ctl.wr && !ctl.load) begin
            pg_q[off] <= wr_data;
        end
    end

    assign ptr     = ptr_q;
    assign mask    = mask_q;
    assign rd_data = pg_q[rd_idx];

    // R2: a stored byte moves only the offset, by one, within the page
    a_r2_offset_step: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr && !ctl.load) |=> (ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + PAGE_W'(1)));
    a_r2_page_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr && !ctl.load) |=> $stable(ptr[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer
    import pgwr_pkg::*;
#(
    parameter int PAGE_W     = 6,
    parameter int CYCLE_CLKS = 625000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              busy,
    output logic              scan_act,
    output logic [PAGE_W-1:0] scan_idx,
    output logic              last
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(CYCLE_CLKS);

    generate
        if (CYCLE_CLKS < PAGE) begin : g_len_check
            $error("CYCLE_CLKS must cover one full page scan");
        end
    endgenerate

    cyc_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy     = (st_q == CY_RUN);
    assign last     = busy && (cnt_q == CNT_W'(CYCLE_CLKS - 1));
    assign scan_act = busy && ({1'b0, cnt_q} < (CNT_W+1)'(PAGE));
    assign scan_idx = cnt_q[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CY_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                CY_IDLE: begin
                    if (go) begin
                        st_q  <= CY_RUN;
                        cnt_q <= '0;
                    end
                end
                CY_RUN: begin
                    if (last) begin
                        st_q <= CY_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= CY_IDLE;
            endcase
        end
    end

    // R5: cycle starts the clock after go and holds until its last clock
    a_r5_go_starts: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int PAGE_W     = 6,
    parameter int CYCLE_CLKS = 625000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              stop_evt,
    input  logic              abort_evt,
    input  logic              wp_in,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    localparam int PAGE = 1 << PAGE_W;

    lat_ctl_t          ctl;
    logic [PAGE-1:0]   mask;
    logic [PAGE_W-1:0] scan_idx;
    logic              scan_act;
    logic              t_last;
    byte_t             rd_data;
    logic              accept, ld, ab, wr, stp, pend, go, reject;

    // Command traffic is taken only outside a write cycle
    assign accept = !busy;
    assign ld     = cmd_start & accept;
    assign ab     = abort_evt & accept & !ld;
    assign wr     = byte_vld  & accept & !ld & !ab;
    assign stp    = stop_evt  & accept & !ld & !ab;
    assign pend   = (|mask) | wr;          // includes a byte arriving with the Stop
    assign go     = stp & pend & !wp_in;   // protect level sampled here only
    assign reject = stp & !go;

    assign ctl.load = ld;
    assign ctl.wr   = wr;
    assign ctl.drop = ab | reject | t_last;

    pgwr_latch #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .load_addr (cmd_addr),
        .wr_data   (byte_data),
        .rd_idx    (scan_idx),
        .ptr       (ptr_addr),
        .mask      (mask),
        .rd_data   (rd_data)
    );

    pgwr_timer #(
        .PAGE_W     (PAGE_W),
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .busy     (busy),
        .scan_act (scan_act),
        .scan_idx (scan_idx),
        .last     (t_last)
    );

    assign arr_we    = scan_act & mask[scan_idx];
    assign arr_addr  = {ptr_addr[ADDR_W-1:PAGE_W], scan_idx};
    assign arr_wdata = rd_data;

    // R4: the array is touched only inside a write cycle
    a_r4_we_in_cycle: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);
    // R8: pointer frozen while the cycle runs
    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr_addr));
    // R6: protected Stop leaves the block idle
    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && wp_in && !busy) |=> !busy);
    // R9: Stop with nothing buffered starts no cycle
    a_r9_empty_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !busy && !byte_vld && (mask == '0)) |=> !busy);

endmodule

// File: tb/pgwr_commit_bench.sv
module pgwr_commit_bench;
    localparam int ADDR_W = 14;
    localparam int PAGE_W = 6;
    localparam int PG     = 1 << PAGE_W;
    localparam int CYC    = 100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_start = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              byte_vld = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              stop_evt = 1'b0;
    logic              abort_evt = 1'b0;
    logic              wp_in = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] ptr_addr;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;

    pgwr_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYC)) u_pgwr_commit (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .abort_evt(abort_evt), .wp_in(wp_in), .busy(busy), .ptr_addr(ptr_addr),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    int tests = 0;
    int fails = 0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int   m_ptr = 0;
    bit   m_busy = 0;
    int   m_cnt = 0;
    bit   m_valid [PG];
    int   m_buf [PG];

    function automatic bit any_valid();
        foreach (m_valid[i]) if (m_valid[i]) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ptr = 0; m_busy = 0; m_cnt = 0;
            foreach (m_valid[i]) m_valid[i] = 0;
        end else if (m_busy) begin
            if (m_cnt == CYC - 1) begin
                m_busy = 0;
                foreach (m_valid[i]) m_valid[i] = 0;
            end else m_cnt++;
        end else if (cmd_start) begin
            m_ptr = cmd_addr;
            foreach (m_valid[i]) m_valid[i] = 0;
        end else if (abort_evt) begin
            foreach (m_valid[i]) m_valid[i] = 0;
        end else begin
            if (byte_vld) begin
                m_buf[m_ptr % PG] = byte_data;
                m_valid[m_ptr % PG] = 1;
                m_ptr = (m_ptr / PG) * PG + ((m_ptr + 1) % PG);
            end
            if (stop_evt) begin
                if (any_valid() && !wp_in) begin
                    m_busy = 1; m_cnt = 0;
                end else begin
                    foreach (m_valid[i]) m_valid[i] = 0;
                end
            end
        end
    end

    // Array image collected from the write port
    logic [7:0] mem_dut [int];
    int wr_count = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit we_exp;
            we_exp = m_busy && (m_cnt < PG) && m_valid[m_cnt % PG];
            chk("R5 busy", int'(busy), int'(m_busy));
            chk("R12 ptr", int'(ptr_addr), m_ptr);
            chk("R4 arr_we", int'(arr_we), int'(we_exp));
            if (arr_we && we_exp) begin
                chk("R4 arr_addr", int'(arr_addr), (m_ptr / PG) * PG + m_cnt);
                chk("R4 arr_wdata", int'(arr_wdata), m_buf[m_cnt]);
            end
            if (arr_we) begin
                mem_dut[int'(arr_addr)] = arr_wdata;
                wr_count++;
            end
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected <100000", wd);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #1;
        cmd_start = 0; byte_vld = 0; stop_evt = 0; abort_evt = 0;
    endtask

    task automatic start_cmd(input int a);
        cmd_start = 1; cmd_addr = ADDR_W'(a); tick();
    endtask

    task automatic put(input int d);
        byte_vld = 1; byte_data = 8'(d); tick();
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; tick(); end
    endtask

    function automatic int rd(input int a);
        if (mem_dut.exists(a)) return int'(mem_dut[a]);
        return -1;
    endfunction

    initial begin
        int n, w0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 ptr", int'(ptr_addr), 0);
        chk("R1 arr_we", int'(arr_we), 0);

        // Single byte write, cycle length, pointer after
        start_cmd(14'h0123); put(8'hA5);
        chk("R4 no write before stop", wr_count, 0);
        stop_evt = 1; tick();
        wait_idle(n);
        chk("R5 busy length", n, CYC);
        chk("R12 ptr after single byte", int'(ptr_addr), 14'h0124);
        chk("R4 stored byte", rd(14'h0123), 8'hA5);
        chk("R4 single write count", wr_count, 1);

        // In-page wrap from offset 62
        w0 = wr_count;
        start_cmd(14'h023E);
        for (int i = 0; i < 4; i++) put(8'h10 + i);
        chk("R2 ptr wraps in page", int'(ptr_addr), 14'h0202);
        stop_evt = 1; tick(); wait_idle(n);
        chk("R2 offset 63", rd(14'h023F), 8'h11);
        chk("R2 offset 0", rd(14'h0200), 8'h12);
        chk("R2 next page untouched", rd(14'h0240), -1);
        chk("R4 wrap write count", wr_count - w0, 4);

        // Overwrite: 70 bytes into page at 0x1000
        w0 = wr_count;
        start_cmd(14'h1000);
        for (int i = 0; i < 70; i++) put(i);
        stop_evt = 1; tick(); wait_idle(n);
        chk("R3 overwritten pos 3", rd(14'h1003), 67);
        chk("R3 kept pos 10", rd(14'h100A), 10);
        chk("R3 write count", wr_count - w0, 64);
        chk("R12 ptr after page", int'(ptr_addr), 14'h1006);

        // Protected Stop, then a bare Stop
        w0 = wr_count;
        start_cmd(14'h2000); put(8'h55); put(8'h66);
        wp_in = 1; stop_evt = 1; tick();
        wp_in = 0;
        chk("R6 busy after protected stop", int'(busy), 0);
        stop_evt = 1; tick();
        chk("R6 bare stop after discard", int'(busy), 0);
        repeat (3) tick();
        chk("R6 no writes", wr_count - w0, 0);

        // Byte with Stop in one clock; wp flips right after; traffic while busy
        w0 = wr_count;
        start_cmd(14'h0C80); put(8'h31);
        byte_vld = 1; byte_data = 8'h32; stop_evt = 1; wp_in = 0; tick();
        wp_in = 1;
        chk("R7 cycle runs", int'(busy), 1);
        cmd_start = 1; cmd_addr = 14'h3000; tick();
        put(8'hEE); abort_evt = 1; tick(); stop_evt = 1; tick();
        wp_in = 0;
        chk("R8 ptr held while busy", int'(ptr_addr), 14'h0C82);
        wait_idle(n);
        chk("R11 byte with stop", rd(14'h0C81), 8'h32);
        chk("R7 first byte", rd(14'h0C80), 8'h31);
        chk("R8 no stray write", rd(14'h3000), -1);
        chk("R8 write count", wr_count - w0, 2);

        // Address-only command
        w0 = wr_count;
        start_cmd(14'h0400); stop_evt = 1; tick();
        chk("R9 no cycle", int'(busy), 0);

        // Abort drops buffer, keeps pointer
        start_cmd(14'h0500); put(1); put(2); put(3);
        abort_evt = 1; tick();
        chk("R10 ptr kept", int'(ptr_addr), 14'h0503);
        stop_evt = 1; tick();
        chk("R10 no cycle", int'(busy), 0);
        repeat (2) tick();
        chk("R10 no writes", wr_count - w0, 0);

        repeat (2) tick();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule